// File: doc/BRIEF.md
# Interrupt Delegation and Priority Selector

This combinational block decides, in the same cycle, whether a hart should take one of its pending interrupts, and which cause code that interrupt reports. The caller supplies the interrupt vector that is already pending and enabled per line, the per-line delegation mask, the current privilege level, the two global interrupt-enable bits (machine and supervisor), and a flag that is high while the hart is halted in debug mode. The block returns a take strobe and a cause word.

The selection runs in two passes. Lines that are not delegated form the machine-level candidates. They are qualified by the machine-level global enable. If no such line survives, the delegated lines form the supervisor-level candidates, qualified by the supervisor-level global enable. Inside the chosen set, the line with the lowest index wins. The cause word carries an interrupt flag in its top bit and the winning index in its low bits.

Top module: `irq_deleg_select`

## Requirements
- R1: Privilege is a 2-bit code: 0 is user, 1 is supervisor, 3 is machine. Code 2 counts as below machine and above supervisor.
- R2: Machine-level interrupts are globally enabled when privilege is below 3, or when it is 3 and `m_ie_i` is 1.
- R3: The machine candidate set is `pend_i & ~deleg_i`, and it is empty when machine-level interrupts are not enabled.
- R4: Only when the machine candidate set is empty, the candidate set becomes `pend_i & deleg_i`, enabled only when privilege is 0, or when it is 1 and `s_ie_i` is 1.
- R5: The winner is the lowest-indexed set bit of the chosen candidate set.
- R6: When `take_o` is 1, `cause_o[XLEN-1]` is 1, `cause_o[IDX_W-1:0]` holds the winning index, and all other bits are 0.
- R7: While `dbg_mode_i` is 1, `take_o` is 0 whatever the other inputs are.
- R8: When both candidate sets are empty, `take_o` is 0 and `cause_o` is all zeros.
- R9: A non-delegated candidate wins over any delegated one, even when the delegated line has a lower index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pend_i | input | IRQ_W | Interrupts that are pending and individually enabled |
| deleg_i | input | IRQ_W | Per-line delegation to the supervisor level |
| priv_i | input | 2 | Current privilege code |
| m_ie_i | input | 1 | Machine-level global interrupt enable |
| s_ie_i | input | 1 | Supervisor-level global interrupt enable |
| dbg_mode_i | input | 1 | High while the hart is in debug mode |
| take_o | output | 1 | An interrupt must be taken now |
| cause_o | output | XLEN | Interrupt flag in the top bit, winning index in the low bits |

## Verification
Several properties are checked by assertions whenever the inputs settle: debug mode blocks the strobe, an idle strobe forces a zero cause word, the interrupt flag accompanies every take, and the reported index is set in the chosen candidate set with no lower bit set. A further assertion checks that at machine privilege a delegated line is never reported. These checks cannot show that the two-pass ordering and the enable rules select the correct set. That needs the bench's exhaustive sweep, which compares every combination against a model computed from the requirements. The sweep covers all pending and delegation patterns, all four privilege codes, both enables and the debug flag, and it includes the reserved privilege code.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // width of an index able to address w lines
  function automatic int idx_width(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/irq_level_gate.sv
// Global enables per level, with debug mode masking both levels.
module irq_level_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       m_ie_i,
  input  logic       s_ie_i,
  input  logic       dbg_mode_i,
  output logic       m_ok_o,
  output logic       s_ok_o
);

  priv_e priv;
  logic  below_mach;
  logic  below_super;

  always_comb begin
    priv        = priv_e'(priv_i);
    below_mach  = (priv != PRIV_MACH);
    below_super = (priv == PRIV_USER);
    m_ok_o = !dbg_mode_i && (below_mach  || (priv == PRIV_MACH)  && m_ie_i);
    s_ok_o = !dbg_mode_i && (below_super || (priv == PRIV_SUPER) && s_ie_i);
  end

  always_comb begin
    a_r7_gate_quiet: assert (!(dbg_mode_i && (m_ok_o || s_ok_o)))
      else $error("debug mode left a level enabled");
  end

endmodule

// File: rtl/irq_lsb_pick.sv
// Lowest-set-bit picker: a one-hot mask built from per-bit prefix ORs,
// then encoded into an index.
module irq_lsb_pick #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  logic [W-1:0] lower_any;
  logic [W-1:0] onehot;

  assign lower_any[0] = 1'b0;
  for (genvar g = 1; g < W; g++) begin : g_prefix
    assign lower_any[g] = |vec_i[g-1:0];
  end

  assign onehot  = vec_i & ~lower_any;
  assign found_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx_o = idx_o | IW'(i);
    end
  end

  always_comb begin
    a_r5_single_winner: assert ($onehot0(onehot))
      else $error("more than one winner bit");
    a_r5_found_match: assert (found_o == (onehot != '0))
      else $error("found flag disagrees with winner mask");
  end

endmodule

// File: rtl/irq_deleg_select.sv
module irq_deleg_select
  import irq_sel_pkg::*;
#(
  parameter int IRQ_W = 16,
  parameter int XLEN  = 64
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             m_ie_i,
  input  logic             s_ie_i,
  input  logic             dbg_mode_i,
  output logic             take_o,
  output logic [XLEN-1:0]  cause_o
);

  localparam int IDX_W = idx_width(IRQ_W);

  logic             m_ok;
  logic             s_ok;
  logic [IRQ_W-1:0] m_set;
  logic [IRQ_W-1:0] s_set;
  logic [IRQ_W-1:0] chosen;
  logic             found;
  logic [IDX_W-1:0] win_idx;

  irq_level_gate u_gate (
    .priv_i     (priv_i),
    .m_ie_i     (m_ie_i),
    .s_ie_i     (s_ie_i),
    .dbg_mode_i (dbg_mode_i),
    .m_ok_o     (m_ok),
    .s_ok_o     (s_ok)
  );

  // first pass: machine level, second pass only when the first is empty
  always_comb begin
    m_set  = pend_i & ~deleg_i & {IRQ_W{m_ok}};
    s_set  = pend_i &  deleg_i & {IRQ_W{s_ok}};
    chosen = (m_set != '0) ? m_set : s_set;
  end

  irq_lsb_pick #(.W(IRQ_W), .IW(IDX_W)) u_pick (
    .vec_i   (chosen),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_comb begin
    take_o  = found;
    cause_o = '0;
    if (found) begin
      cause_o[XLEN-1]    = 1'b1;
      cause_o[IDX_W-1:0] = win_idx;
    end
  end

  always_comb begin
    a_r7_debug_blocks: assert (!(dbg_mode_i && take_o))
      else $error("interrupt taken in debug mode");
    a_r8_idle_zero: assert (take_o || cause_o == '0)
      else $error("cause not zero while idle");
    a_r6_flag_set: assert (!take_o || cause_o[XLEN-1])
      else $error("interrupt flag missing");
    if (take_o) begin
      a_r5_winner_pending: assert (pend_i[cause_o[IDX_W-1:0]])
        else $error("winner is not pending");
      a_r5_nothing_lower: assert ((chosen & ((IRQ_W'(1) << cause_o[IDX_W-1:0]) - IRQ_W'(1))) == '0)
        else $error("a lower candidate was skipped");
      a_r9_mach_no_deleg: assert (!(priv_i == 2'd3 && deleg_i[cause_o[IDX_W-1:0]]))
        else $error("delegated line reported at machine privilege");
    end
  end

endmodule

// File: tb/irq_deleg_select_test.sv
module irq_deleg_select_test;

  localparam int IRQ_W = 5;
  localparam int XLEN  = 64;
  localparam int IDX_W = 3;

  logic clk;
  logic rst_n;
  logic [IRQ_W-1:0] pend;
  logic [IRQ_W-1:0] deleg;
  logic [1:0]       priv;
  logic             mie;
  logic             sie;
  logic             dbg;
  logic             take;
  logic [XLEN-1:0]  cause;

  int n_tests;
  int n_fail;
  bit done;

  irq_deleg_select #(.IRQ_W(IRQ_W), .XLEN(XLEN)) uut (
    .pend_i     (pend),
    .deleg_i    (deleg),
    .priv_i     (priv),
    .m_ie_i     (mie),
    .s_ie_i     (sie),
    .dbg_mode_i (dbg),
    .take_o     (take),
    .cause_o    (cause)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // model built from the requirements
  function automatic void model(input logic [IRQ_W-1:0] p, input logic [IRQ_W-1:0] d,
                                input int pv, input bit me, input bit se, input bit db,
                                output bit t, output logic [XLEN-1:0] c, output bit from_m);
    bit m_en, s_en;
    int m_vec, s_vec, v;
    m_en = !db && ((pv < 3) || (pv == 3 && me));
    s_en = !db && ((pv == 0) || (pv == 1 && se));
    m_vec = m_en ? int'(p & ~d) : 0;
    s_vec = s_en ? int'(p & d) : 0;
    from_m = (m_vec != 0);
    v = from_m ? m_vec : s_vec;
    t = (v != 0);
    c = '0;
    if (t) begin
      int k = 0;
      while (((v >> k) & 1) == 0) k++;
      c = (64'd1 << (XLEN-1)) | 64'(k);
    end
  endfunction

  task automatic apply(input logic [IRQ_W-1:0] p, input logic [IRQ_W-1:0] d,
                       input int pv, input bit me, input bit se, input bit db,
                       input string tag);
    bit et, fm;
    logic [XLEN-1:0] ec;
    string t_tag;
    @(posedge clk);
    pend = p; deleg = d; priv = 2'(pv); mie = me; sie = se; dbg = db;
    model(p, d, pv, me, se, db, et, ec, fm);
    @(negedge clk);
    if (tag != "") t_tag = tag;
    else if (db) t_tag = "R7";
    else if (!et) t_tag = "R8";
    else if (fm) t_tag = "R3";
    else t_tag = "R4";
    n_tests++;
    if (take !== et) begin
      n_fail++;
      $display("FAIL %s take p=%b d=%b priv=%0d mie=%0d sie=%0d dbg=%0d: got %0b exp %0b",
               t_tag, p, d, pv, me, se, db, take, et);
    end
    n_tests++;
    if (cause !== ec) begin
      n_fail++;
      $display("FAIL %s/R6 cause p=%b d=%b priv=%0d: got %h exp %h",
               t_tag, p, d, pv, cause, ec);
    end
  endtask

  task automatic expect_val(input string tag, input logic [XLEN-1:0] got,
                            input logic [XLEN-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    pend = '0; deleg = '0; priv = 2'd3; mie = 1'b0; sie = 1'b0; dbg = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset-like quiet state: nothing pending
    expect_val("R8 quiet take", 64'(take), 64'd0);
    expect_val("R8 quiet cause", cause, 64'd0);

    // R1: code 2 is below machine and not supervisor
    apply(5'b00100, 5'b00000, 2, 0, 1, 0, "R1");
    expect_val("R1 rsvd non-deleg index", cause, (64'd1 << 63) | 64'd2);
    apply(5'b00100, 5'b00100, 2, 1, 1, 0, "R1");
    expect_val("R1 rsvd deleg blocked", 64'(take), 64'd0);
    // R2: machine privilege requires mie
    apply(5'b00010, 5'b00000, 3, 0, 1, 0, "R2");
    expect_val("R2 mie clear blocks", 64'(take), 64'd0);
    apply(5'b00010, 5'b00000, 3, 1, 0, 0, "R2");
    expect_val("R2 mie set takes", cause, (64'd1 << 63) | 64'd1);
    // R9: non-delegated line at index 4 beats delegated line at index 0
    apply(5'b10001, 5'b00001, 0, 0, 0, 0, "R9");
    expect_val("R9 machine wins", cause, (64'd1 << 63) | 64'd4);
    // R5: lowest index in a dense set
    apply(5'b11110, 5'b00000, 1, 0, 0, 0, "R5");
    expect_val("R5 lowest bit", cause, (64'd1 << 63) | 64'd1);
    // R4: supervisor with sie, delegated only
    apply(5'b01000, 5'b01000, 1, 0, 1, 0, "R4");
    expect_val("R4 deleg at super", cause, (64'd1 << 63) | 64'd3);
    // R7: debug mode masks everything
    apply(5'b11111, 5'b01010, 0, 1, 1, 1, "R7");
    expect_val("R7 debug quiet", 64'(take), 64'd0);

    // exhaustive sweep
    for (int p = 0; p < (1 << IRQ_W); p++)
      for (int d = 0; d < (1 << IRQ_W); d++)
        for (int pv = 0; pv < 4; pv++)
          for (int e = 0; e < 8; e++)
            apply(IRQ_W'(p), IRQ_W'(d), pv, e[0], e[1], e[2], "");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule